// File: doc/BRIEF.md
# Four-Level Prioritized Interrupt Controller

This block sits beside a small 8-bit processor core and arbitrates six interrupt sources. There are two external pins, two timer overflow events, one serial-port flag and one second-timer flag. Software programs a global/individual enable register, two priority registers and a trigger-mode register through a byte-wide register port. The high and low priority bits of a source together select one of four levels.

The core sees a request line together with the vector of the winning source in the same cycle. It answers with a single-cycle acknowledge, which marks the granted level as in service and clears any flag that hardware is meant to clear. A single-cycle return pulse ends service at the highest active level. A request is offered only when its level is above every level now in service, so interrupts nest by level and a preempted lower level takes over again once the higher one returns.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and the request output is low.
- R2: Register addresses are: enable 0xA8, priority-low 0xB8, priority-high 0xB7, trigger-mode 0x88 (bit 0 = external 0 edge mode, bit 1 = external 1 edge mode). Enable bit 6 is reserved and reads 0. Any other address reads 0x00.
- R3: Enable bit 7 gates everything: when it is 0 no request is raised. Enable bits 0..5 gate, in order, external 0, timer 0, external 1, timer 1, serial port and timer 2. Priority bits use the same bit positions.
- R4: A source's level is {priority-high bit, priority-low bit}: 00 lowest, 11 highest. A higher level wins whatever the source order.
- R5: Among pending sources at equal level the winner follows the fixed order external 0, timer 0, external 1, timer 1, serial port, timer 2.
- R6: The vector is 0x03, 0x0B, 0x13, 0x1B, 0x23 or 0x2B for the six sources in that order, and it is valid while the request is high.
- R7: A request is raised only if its level is strictly above every level in service. An acknowledge while the request is high marks the granted level as in service.
- R8: A return pulse clears only the highest in-service level, and lower levels stay in service.
- R9: In level mode an external source requests while its synchronized pin is low, and acknowledge does not clear it.
- R10: In edge mode a falling edge on the synchronized external pin latches a flag that stays set after the pin rises and is cleared by acknowledge of that source.
- R11: A timer 0 or timer 1 overflow pulse latches a flag that acknowledge of that source clears.
- R12: The serial-port and timer 2 requests follow their inputs and are never cleared by acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ext0_n | input | 1 | External source 0 pin, active low |
| ext1_n | input | 1 | External source 1 pin, active low |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| ser_flag | input | 1 | Serial-port request flag |
| tmr2_flag | input | 1 | Timer 2 request flag |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the winning source |
| irq_ack | input | 1 | Acknowledge pulse from the core |
| irq_reti | input | 1 | Return-from-interrupt pulse |

## Verification
A stale or wrongly set in-service bit shows at once as a request that stays low while a higher-level source is pending, or as a request that appears for a level that should be blocked. Both are visible in the cycle after the acknowledge or return that caused them. A flag that is not cleared shows as the same vector coming back right after a return. A flag cleared when it should not be shows as a missing request in that cycle. An arbitration error shows as the wrong vector in the first cycle two sources are pending together.

// File: rtl/prio_irq_ctrl_pkg.sv
// Package: shared sizes, register addresses and vector computation for the
// prioritized interrupt controller. Assumes source index order is the
// fixed polling order (lower index wins ties).
package prio_irq_ctrl_pkg;
    localparam int NSRC   = 6;
    localparam int NLVL   = 4;
    localparam int LVLW   = $clog2(NLVL);
    localparam int IDXW   = $clog2(NSRC);
    localparam int NEXT   = 2;

    localparam logic [7:0] ADDR_ENABLE = 8'hA8;
    localparam logic [7:0] ADDR_PRIO_L = 8'hB8;
    localparam logic [7:0] ADDR_PRIO_H = 8'hB7;
    localparam logic [7:0] ADDR_MODE   = 8'h88;

    localparam logic [7:0] VEC_BASE = 8'h03;
    localparam logic [7:0] VEC_STEP = 8'h08;

    typedef logic [LVLW-1:0] lvl_t;
    typedef logic [IDXW-1:0] idx_t;

    // Vector address for a source index.
    function automatic logic [7:0] vec_of(idx_t idx);
        return VEC_BASE + VEC_STEP * 8'(idx);
    endfunction
endpackage

// File: rtl/prio_irq_regs.sv
// Register file: enable, priority-low, priority-high and trigger-mode.
// Assumes a single-cycle write strobe; reads are combinational.
module prio_irq_regs
    import prio_irq_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [7:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    output logic            glob_en,
    output logic [NSRC-1:0] src_en,
    output logic [NSRC-1:0] prio_lo,
    output logic [NSRC-1:0] prio_hi,
    output logic [NEXT-1:0] edge_mode
);
    logic [NSRC-1:0] en_q, pl_q, ph_q;
    logic            ea_q;
    logic [NEXT-1:0] md_q;

    // Register writes, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0; pl_q <= '0; ph_q <= '0; ea_q <= 1'b0; md_q <= '0;
        end else if (we) begin
            unique case (addr)
                ADDR_ENABLE: begin ea_q <= wdata[7]; en_q <= wdata[NSRC-1:0]; end
                ADDR_PRIO_L: pl_q <= wdata[NSRC-1:0];
                ADDR_PRIO_H: ph_q <= wdata[NSRC-1:0];
                ADDR_MODE:   md_q <= wdata[NEXT-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer; reserved bits read zero.
    always_comb begin
        rdata = 8'h00;
        unique case (addr)
            ADDR_ENABLE: rdata = {ea_q, 7'(en_q)};
            ADDR_PRIO_L: rdata = 8'(pl_q);
            ADDR_PRIO_H: rdata = 8'(ph_q);
            ADDR_MODE:   rdata = 8'(md_q);
            default:     rdata = 8'h00;
        endcase
    end

    assign glob_en   = ea_q;
    assign src_en    = en_q;
    assign prio_lo   = pl_q;
    assign prio_hi   = ph_q;
    assign edge_mode = md_q;

    a_r2_enable_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_ENABLE) |=> (glob_en == $past(wdata[7])) && (src_en == $past(wdata[NSRC-1:0])));
endmodule

// File: rtl/prio_irq_src.sv
// Source capture: synchronizes the external pins and produces one request
// flag per source. External flags are edge-latched or level-following per
// mode; timer 0/1 flags latch overflow pulses; serial and timer 2 pass through.
// clr is a one-hot acknowledge clear from the arbiter.
module prio_irq_src
    import prio_irq_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEXT-1:0] ext_n,
    input  logic [NEXT-1:0] tmr_ovf,
    input  logic            ser_flag,
    input  logic            tmr2_flag,
    input  logic [NEXT-1:0] edge_mode,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] flags
);
    for (genvar g = 0; g < NEXT; g++) begin : g_pair
        logic s1_q, s2_q, prev_q, edge_q, tf_q;
        logic fall;
        assign fall = prev_q & ~s2_q;

        // Two-stage pin synchronizer plus a delayed copy for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= 1'b1; s2_q <= 1'b1; prev_q <= 1'b1;
            end else begin
                s1_q <= ext_n[g]; s2_q <= s1_q; prev_q <= s2_q;
            end
        end

        // Edge flag: set on a falling edge (set wins), cleared by acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                 edge_q <= 1'b0;
            else if (fall)              edge_q <= 1'b1;
            else if (clr[2*g])          edge_q <= 1'b0;
        end

        // Timer overflow flag: set on pulse (set wins), cleared by acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)                 tf_q <= 1'b0;
            else if (tmr_ovf[g])        tf_q <= 1'b1;
            else if (clr[2*g+1])        tf_q <= 1'b0;
        end

        assign flags[2*g]   = edge_mode[g] ? edge_q : ~s2_q;
        assign flags[2*g+1] = tf_q;

        a_r11_tmr_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[2*g+1] && !tmr_ovf[g]) |=> !flags[2*g+1]);
        a_r10_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode[g] && $past(edge_mode[g]) && $past(flags[2*g]) && !$past(clr[2*g])) |-> flags[2*g]);
    end

    assign flags[4] = ser_flag;
    assign flags[5] = tmr2_flag;
endmodule

// File: rtl/prio_irq_arb.sv
// Arbiter and in-service tracker: picks the highest-level enabled pending
// source (lowest index on ties), offers it only above the top in-service
// level, and keeps one in-service bit per level. Assumes ack and reti are
// single-cycle pulses.
module prio_irq_arb
    import prio_irq_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags,
    input  logic            glob_en,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] prio_lo,
    input  logic [NSRC-1:0] prio_hi,
    input  logic            ack,
    input  logic            reti,
    output logic            req,
    output logic [7:0]      vec,
    output logic [NSRC-1:0] clr
);
    logic [NSRC-1:0] pend;
    logic [NLVL-1:0] isr_q, isr_set, isr_clr;
    logic            found, any_isr, grant;
    lvl_t            win_lvl, top_lvl;
    idx_t            win_idx;

    assign pend = glob_en ? (flags & src_en) : '0;

    // Winner search: strictly higher level replaces, so lower index wins ties.
    always_comb begin
        found = 1'b0; win_lvl = '0; win_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!found || lvl_t'({prio_hi[i], prio_lo[i]}) > win_lvl)) begin
                found   = 1'b1;
                win_lvl = lvl_t'({prio_hi[i], prio_lo[i]});
                win_idx = idx_t'(i);
            end
        end
    end

    // Highest in-service level and its one-hot clear mask for a return.
    always_comb begin
        any_isr = 1'b0; top_lvl = '0; isr_clr = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (isr_q[l]) begin any_isr = 1'b1; top_lvl = lvl_t'(l); end
        end
        if (reti && any_isr) isr_clr[top_lvl] = 1'b1;
    end

    assign req     = found && (!any_isr || win_lvl > top_lvl);
    assign vec     = req ? vec_of(win_idx) : 8'h00;
    assign grant   = ack && req;
    assign isr_set = grant ? (NLVL'(1) << win_lvl) : '0;
    assign clr     = grant ? (NSRC'(1) << win_idx) : '0;

    // In-service mask update: return clears the top level, grant sets its level.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~isr_clr) | isr_set;
    end

    a_r7_grant_marks: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> isr_q[$past(win_lvl)]);
    a_r8_reti_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !grant && isr_q != '0) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
    a_r3_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> !req);
    a_r6_vec_form: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (vec[2:0] == 3'b011 && vec <= 8'h2B));
    a_r7_onehot_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: four-level prioritized interrupt controller with six sources.
// Connects the register file, source capture and arbiter.
module prio_irq_ctrl
    import prio_irq_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ext0_n,
    input  logic       ext1_n,
    input  logic       tmr0_ovf,
    input  logic       tmr1_ovf,
    input  logic       ser_flag,
    input  logic       tmr2_flag,
    output logic       irq_req,
    output logic [7:0] irq_vec,
    input  logic       irq_ack,
    input  logic       irq_reti
);
    logic            glob_en;
    logic [NSRC-1:0] src_en, prio_lo, prio_hi, flags, clr;
    logic [NEXT-1:0] edge_mode;

    prio_irq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .glob_en(glob_en),
        .src_en(src_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
        .edge_mode(edge_mode)
    );

    prio_irq_src u_src (
        .clk(clk), .rst_n(rst_n), .ext_n({ext1_n, ext0_n}),
        .tmr_ovf({tmr1_ovf, tmr0_ovf}), .ser_flag(ser_flag),
        .tmr2_flag(tmr2_flag), .edge_mode(edge_mode), .clr(clr),
        .flags(flags)
    );

    prio_irq_arb u_arb (
        .clk(clk), .rst_n(rst_n), .flags(flags), .glob_en(glob_en),
        .src_en(src_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
        .ack(irq_ack), .reti(irq_reti), .req(irq_req), .vec(irq_vec),
        .clr(clr)
    );
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext0_n = 1'b1, ext1_n = 1'b1;
    logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
    logic       ser_flag = 1'b0, tmr2_flag = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_ack = 1'b0, irq_reti = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        bit        is_rd;
        logic [7:0] exp_rd;
        logic       exp_req;
        logic [7:0] exp_vec;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext0_n(ext0_n),
        .ext1_n(ext1_n), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .ser_flag(ser_flag), .tmr2_flag(tmr2_flag), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_reti(irq_reti)
    );

    // Monitor: pops one expected item per falling edge and compares.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.is_rd) begin
                if (reg_rdata !== it.exp_rd) begin
                    errors++;
                    $display("FAIL %s: rdata actual=%h expected=%h", it.tag, reg_rdata, it.exp_rd);
                end
            end else if (irq_req !== it.exp_req || (it.exp_req && irq_vec !== it.exp_vec)) begin
                errors++;
                $display("FAIL %s: req/vec actual=%b/%h expected=%b/%h",
                         it.tag, irq_req, irq_vec, it.exp_req, it.exp_vec);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic exp_rd(logic [7:0] a, logic [7:0] d, string tag);
        item_t it;
        reg_addr = a;
        it.is_rd = 1'b1; it.exp_rd = d; it.exp_req = 1'b0; it.exp_vec = 8'h00; it.tag = tag;
        sb.push_back(it);
        step();
    endtask

    task automatic exp_irq(logic r, logic [7:0] v, string tag);
        item_t it;
        it.is_rd = 1'b0; it.exp_rd = 8'h00; it.exp_req = r; it.exp_vec = v; it.tag = tag;
        sb.push_back(it);
        step();
    endtask

    task automatic ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
    endtask

    task automatic reti();
        irq_reti = 1'b1; step(); irq_reti = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        exp_rd(8'hA8, 8'h00, "R1 enable");
        exp_rd(8'hB7, 8'h00, "R1 prio-high");
        exp_irq(1'b0, 8'h00, "R1 no request");
        // R2 register map
        wr(8'hA8, 8'hFF);
        exp_rd(8'hA8, 8'hBF, "R2 reserved bit reads 0");
        wr(8'hB7, 8'h3F);
        exp_rd(8'hB7, 8'h3F, "R2 prio-high");
        wr(8'hB7, 8'h00);
        exp_rd(8'h10, 8'h00, "R2 unmapped address");
        // R3 gating
        wr(8'hA8, 8'h3F);
        ser_flag = 1'b1;
        exp_irq(1'b0, 8'h00, "R3 global enable off");
        wr(8'hA8, 8'h90);
        exp_irq(1'b1, 8'h23, "R3 R6 serial enabled");
        wr(8'hA8, 8'h80);
        exp_irq(1'b0, 8'h00, "R3 serial individually off");
        wr(8'hA8, 8'hBF);
        // R5 order at equal level
        tmr2_flag = 1'b1;
        exp_irq(1'b1, 8'h23, "R5 serial before timer2");
        tmr0_ovf = 1'b1; step(); tmr0_ovf = 1'b0;
        exp_irq(1'b1, 8'h0B, "R5 timer0 before serial");
        // R4 higher level wins
        wr(8'hB8, 8'h20); wr(8'hB7, 8'h20);
        exp_irq(1'b1, 8'h2B, "R4 timer2 at level 3");
        ack();
        exp_irq(1'b0, 8'h00, "R7 level 3 in service blocks all");
        reti();
        exp_irq(1'b1, 8'h2B, "R12 R8 timer2 not cleared, returns");
        wr(8'hB8, 8'h00); wr(8'hB7, 8'h00);
        tmr2_flag = 1'b0;
        exp_irq(1'b1, 8'h0B, "R11 timer0 still pending");
        ack();
        exp_irq(1'b0, 8'h00, "R7 equal level blocked");
        wr(8'hB8, 8'h10);
        exp_irq(1'b1, 8'h23, "R7 level 1 preempts level 0");
        ack();
        exp_irq(1'b0, 8'h00, "R7 levels 0 and 1 in service");
        reti();
        exp_irq(1'b1, 8'h23, "R8 only level 1 cleared");
        wr(8'hB8, 8'h00);
        exp_irq(1'b0, 8'h00, "R8 level 0 still in service");
        reti();
        exp_irq(1'b1, 8'h23, "R11 timer0 cleared, serial left");
        ser_flag = 1'b0;
        exp_irq(1'b0, 8'h00, "R12 serial follows input");
        // R9 level mode external 0
        ext0_n = 1'b0;
        step(3);
        exp_irq(1'b1, 8'h03, "R9 level low requests");
        ack(); reti();
        exp_irq(1'b1, 8'h03, "R9 not cleared by ack");
        ext0_n = 1'b1;
        step(3);
        exp_irq(1'b0, 8'h00, "R9 pin high drops request");
        // R10 edge mode external 1
        wr(8'h88, 8'h02);
        exp_rd(8'h88, 8'h02, "R2 trigger-mode register");
        ext1_n = 1'b0; step(2); ext1_n = 1'b1;
        step(4);
        exp_irq(1'b1, 8'h13, "R10 edge latched after pin high");
        ack(); reti();
        exp_irq(1'b0, 8'h00, "R10 cleared by ack");
        // R11 timer 1
        tmr1_ovf = 1'b1; step(); tmr1_ovf = 1'b0;
        exp_irq(1'b1, 8'h1B, "R11 timer1 latched");
        ack(); reti();
        exp_irq(1'b0, 8'h00, "R11 timer1 cleared by ack");
        step(2);
        finish_run();
    end
endmodule